// File: doc/BRIEF.md
# Body-Bias Sweep Health Monitor

This block calibrates and watches the health of a single body-bias domain, one domain per processing element. On request it steps a signed bias code from the most reverse setting toward forward, one 100 mV step at a time. At each step it waits a programmable number of settle cycles and then samples the pass/fail result of an on-chip critical-path test circuit. The first step that passes is the slowest bias at which the circuit still meets timing.

A calibration run hands this passing code to the external non-volatile store as the domain's reference. A monitor run compares the new passing code against that stored reference. The comparison adds a signed temperature correction and a tolerated margin, both in steps. A domain that now needs more forward bias than the corrected reference plus margin is flagged as degraded. The forward end of the sweep is clamped at +13 (1.3 V). If nothing passes up to that ceiling, a fail flag is raised instead.

Top module: `bb_health_mon`

## Requirements
- R1: After reset, bias_code_o is -16, and busy_o, done_o, ref_wr_o, degrade_o and fail_o are all 0.
- R2: A start_i pulse seen while idle begins a sweep at code -16. Each code is held for settle_i+1 cycles, and test_pass_i is sampled in the last of them. When the first passing code is -16+j, done_o rises (j+1)*(settle_i+1) cycles after the edge that accepted start_i.
- R3: The sweep stops at the first passing code. min_pass_o then shows that code, and bias_code_o keeps holding it until the next start.
- R4: In a calibration run (calib_i=1 at start), ref_wr_o pulses for one cycle together with done_o, with min_pass_o as the data to store, and degrade_o stays 0.
- R5: In a monitor run (calib_i=0), degrade_o is set at done when the passing code is greater than ref_i + temp_adj_i + margin_i. The first two are signed 5-bit values and margin_i is unsigned 4-bit, all in steps. No reference write occurs.
- R6: bias_code_o never exceeds +13. If no code from -16 to +13 passes, done_o rises after 30*(settle_i+1) cycles with fail_o=1, degrade_o=0 and no reference write.
- R7: start_i is ignored while a sweep is running; the sweep timing and result are unchanged.
- R8: done_o is a one-cycle pulse. busy_o is 1 from the cycle after start is accepted until done_o rises. The result flags hold until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a sweep (accepted when idle) |
| calib_i | input | 1 | 1 = calibration run, 0 = monitor run |
| settle_i | input | 12 | Extra wait cycles per step before sampling |
| ref_i | input | 5 | Stored reference code, signed |
| temp_adj_i | input | 5 | Temperature correction in steps, signed |
| margin_i | input | 4 | Tolerated steps above corrected reference |
| test_pass_i | input | 1 | Critical-path test circuit result |
| bias_code_o | output | 5 | Bias DAC code, signed, 100 mV per step |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | Sweep finished (one-cycle pulse) |
| min_pass_o | output | 5 | Lowest passing code of the last run |
| ref_wr_o | output | 1 | Write min_pass_o to non-volatile storage |
| degrade_o | output | 1 | Wear detected on last monitor run |
| fail_o | output | 1 | No step passed up to the ceiling |

## Verification
The bench goes after the sweep end points: a circuit that passes at -16, one that passes only at +13, and one that never passes. An off-by-one limit would show there as a sweep past the ceiling, a missing fail flag or a wrong stop code. Degradation is probed exactly at the threshold and one step beyond it, with positive and negative temperature corrections and with the largest margin. A compare that is unsigned or off by one would flip the flag at those points. Each run's length is timed against the settle count, so a design that sampled too early or held steps for the wrong count would finish on the wrong cycle. A second start issued mid-sweep must leave that timing unchanged.

// File: rtl/bb_health_mon.sv
module bb_health_mon #(
  parameter int CODE_W   = 5,
  parameter int CODE_MIN = -16,
  parameter int CODE_MAX = 13,
  parameter int SETTLE_W = 12,
  parameter int MARGIN_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic                       calib_i,
  input  logic [SETTLE_W-1:0]        settle_i,
  input  logic signed [CODE_W-1:0]   ref_i,
  input  logic signed [CODE_W-1:0]   temp_adj_i,
  input  logic [MARGIN_W-1:0]        margin_i,
  input  logic                       test_pass_i,
  output logic signed [CODE_W-1:0]   bias_code_o,
  output logic                       busy_o,
  output logic                       done_o,
  output logic signed [CODE_W-1:0]   min_pass_o,
  output logic                       ref_wr_o,
  output logic                       degrade_o,
  output logic                       fail_o
);
  localparam int EXT_W = CODE_W + MARGIN_W;
  localparam logic signed [CODE_W-1:0] MIN_C = CODE_W'(CODE_MIN);
  localparam logic signed [CODE_W-1:0] MAX_C = CODE_W'(CODE_MAX);
  localparam logic signed [CODE_W-1:0] ONE_C = CODE_W'(1);

  typedef enum logic {IDLE, SWEEP} state_t;
  state_t state;

  logic [SETTLE_W-1:0]      cnt, settle_q;
  logic                     calib_q;
  logic signed [EXT_W-1:0]  limit_q, code_ext, limit_d;

  assign code_ext = EXT_W'(bias_code_o);
  assign limit_d  = EXT_W'(ref_i) + EXT_W'(temp_adj_i) + EXT_W'(margin_i);
  assign busy_o   = (state == SWEEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= IDLE;
      bias_code_o <= MIN_C;
      cnt         <= '0;
      settle_q    <= '0;
      calib_q     <= 1'b0;
      limit_q     <= '0;
      min_pass_o  <= MIN_C;
      done_o      <= 1'b0;
      ref_wr_o    <= 1'b0;
      degrade_o   <= 1'b0;
      fail_o      <= 1'b0;
    end else begin
      done_o   <= 1'b0;
      ref_wr_o <= 1'b0;
      case (state)
        IDLE: if (start_i) begin
          state       <= SWEEP;
          bias_code_o <= MIN_C;
          cnt         <= '0;
          settle_q    <= settle_i;
          calib_q     <= calib_i;
          limit_q     <= limit_d;
          degrade_o   <= 1'b0;
          fail_o      <= 1'b0;
        end
        SWEEP: begin
          if (cnt != settle_q) begin
            cnt <= cnt + 1'b1;
          end else if (test_pass_i) begin
            state      <= IDLE;
            done_o     <= 1'b1;
            min_pass_o <= bias_code_o;
            if (calib_q) ref_wr_o  <= 1'b1;
            else         degrade_o <= (code_ext > limit_q);
          end else if (bias_code_o == MAX_C) begin
            state  <= IDLE;
            done_o <= 1'b1;
            fail_o <= 1'b1;
          end else begin
            bias_code_o <= bias_code_o + ONE_C;
            cnt         <= '0;
          end
        end
        default: state <= IDLE;
      endcase
    end
  end

  a_r6_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    bias_code_o <= MAX_C);
  a_r6_fail_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(fail_o && (degrade_o || ref_wr_o)));
  a_r4_wr_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    ref_wr_o |-> (done_o && !degrade_o));
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && !$stable(bias_code_o)) |-> (bias_code_o == $past(bias_code_o) + ONE_C));
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && $past(!busy_o)) |-> $stable(bias_code_o));
endmodule

// File: tb/tb_bb_health_mon.sv
`timescale 1ns/1ps
module tb_bb_health_mon;
  logic clk = 0, rst_n = 0, start_i = 0, calib_i = 0, test_pass_i;
  logic [11:0] settle_i = 0;
  logic signed [4:0] ref_i = 0, temp_adj_i = 0, bias_code_o, min_pass_o;
  logic [3:0] margin_i = 0;
  logic busy_o, done_o, ref_wr_o, degrade_o, fail_o;
  int thr = 100;
  int n_chk = 0, n_bad = 0, cyc = 0;

  always #4 clk = ~clk;
  assign test_pass_i = (int'(bias_code_o) >= thr);

  bb_health_mon dut (.clk(clk), .rst_n(rst_n), .start_i(start_i), .calib_i(calib_i),
    .settle_i(settle_i), .ref_i(ref_i), .temp_adj_i(temp_adj_i), .margin_i(margin_i),
    .test_pass_i(test_pass_i), .bias_code_o(bias_code_o), .busy_o(busy_o), .done_o(done_o),
    .min_pass_o(min_pass_o), .ref_wr_o(ref_wr_o), .degrade_o(degrade_o), .fail_o(fail_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin n_bad++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  localparam int NV = 9;
  localparam int V_CAL[NV] = '{1, 0, 0, 0, 0, 0, 0, 1, 0};
  localparam int V_SET[NV] = '{2, 1, 0, 3, 1, 2, 1, 0, 0};
  localparam int V_THR[NV] = '{-3, -3, -1, -1, 0, -16, 14, 13, 5};
  localparam int V_REF[NV] = '{0, -3, -3, -3, -3, -10, 0, 0, -16};
  localparam int V_TMP[NV] = '{0, 0, 0, 2, 2, -4, 0, 0, -16};
  localparam int V_MRG[NV] = '{0, 0, 1, 0, 0, 0, 0, 0, 15};
  localparam int V_DEG[NV] = '{0, 0, 1, 0, 1, 0, 0, 0, 1};

  task automatic run(input int cal, input int s, input int t, input int rf, input int tp,
                     input int mg, input int edeg, input bit restart);
    int n = 0; int wr = 0; int busy_bad = 0;
    int ecode = (t > 13) ? 13 : ((t < -16) ? -16 : t);
    int efail = (t > 13);
    int ecyc = efail ? 30 * (s + 1) : (ecode + 17) * (s + 1);
    @(negedge clk);
    calib_i = cal[0]; settle_i = 12'(s); thr = t;
    ref_i = 5'(rf); temp_adj_i = 5'(tp); margin_i = 4'(mg);
    start_i = 1;
    @(posedge clk);
    @(negedge clk); start_i = 0;
    while (!done_o && n < 5000) begin
      if (!busy_o) busy_bad++;
      if (ref_wr_o) wr++;
      if (restart && n == 5) start_i = 1;
      if (restart && n == 6) start_i = 0;
      @(posedge clk); n++; @(negedge clk);
    end
    chk(n == ecyc, "R2 sweep length", n, ecyc);
    chk(busy_bad == 0 && busy_o == 0, "R8 busy window", busy_bad, 0);
    chk(fail_o == efail[0], "R6 fail flag", fail_o, efail);
    chk(int'(bias_code_o) == ecode, "R3/R6 held bias code", bias_code_o, ecode);
    if (!efail) chk(int'(min_pass_o) == t, "R3 min pass code", min_pass_o, t);
    chk(ref_wr_o == (cal != 0 && !efail), "R4 ref write", ref_wr_o, cal != 0 && !efail);
    chk(wr == 0, "R4 no early write", wr, 0);
    chk(degrade_o == edeg[0], "R5 degrade flag", degrade_o, edeg);
    @(negedge clk);
    chk(done_o == 0 && ref_wr_o == 0, "R8 done one cycle", done_o, 0);
    chk(degrade_o == edeg[0] && fail_o == efail[0], "R8 flags hold", degrade_o, edeg);
    chk(int'(bias_code_o) == ecode, "R3 bias holds idle", bias_code_o, ecode);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(bias_code_o == -5'sd16, "R1 reset bias", bias_code_o, -16);
    chk({busy_o, done_o, ref_wr_o, degrade_o, fail_o} == 5'b0, "R1 reset flags",
        {busy_o, done_o, ref_wr_o, degrade_o, fail_o}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(busy_o == 0 && bias_code_o == -5'sd16, "R1 idle after reset", busy_o, 0);
    for (int i = 0; i < NV; i++)
      run(V_CAL[i], V_SET[i], V_THR[i], V_REF[i], V_TMP[i], V_MRG[i], V_DEG[i], 1'b0);
    // R7: second start mid-sweep must not restart or shorten
    run(0, 1, 0, 0, 0, 0, 0, 1'b1);
    // R5 boundary: exactly at corrected limit, then one step above
    run(0, 0, 2, 0, 1, 1, 0, 1'b0);
    run(0, 0, 3, 0, 1, 1, 1, 1'b0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule